// File: doc/BRIEF.md
# Dual-Bank Register Pair File with Alternate-Destination Prefix

This block holds four 16-bit register pairs (accumulator/flags, and three general pairs), each with a shadow copy in a second bank. Every pair has its own bank-select bit, which says which physical copy is currently the primary one. Exchanging banks toggles select bits and moves no data, so each exchange takes one clock. A separate swap between the two upper general pairs does move data, because it pairs registers of different names.

A one-shot prefix strobe arms a redirect for the next operation. Two controls, sampled with the strobe, choose whether that operation's register result, its flag result, or both go to the shadow bank. While the prefix is armed, the pair-swap exchange pairs the primary third pair with the shadow fourth pair instead of the primary fourth pair. Dedicated copy operations move a primary general pair into any shadow pair. Reads always return primary values, on any number of read ports.

Top module: `dual_bank_regfile`

## Requirements
- R1: After reset every pair reads zero in both banks, all bank-select bits are clear and no prefix is armed. Pair codes are 0 accumulator/flags (AF), 1 (BC), 2 (DE), 3 (HL).
- R2: With no prefix armed, `wr_en` writes `wr_data` into the primary copy of pair `wr_sel`, visible on every read port the cycle after the edge. Without any operation strobe all read values hold.
- R3: `ex_all` swaps pairs 1, 2 and 3 with their shadow copies in one clock and leaves pair 0 untouched.
- R4: `ex_af` swaps pair 0 with its shadow copy in one clock and leaves pairs 1 to 3 untouched.
- R5: `ex_dehl` without an armed register redirect swaps the primary contents of pairs 2 and 3.
- R6: `ex_dehl` with an armed register redirect swaps primary pair 2 with shadow pair 3; primary pair 3 and shadow pair 2 are unchanged.
- R7: An armed register redirect sends the next `wr_en` write to the shadow copy of `wr_sel`; the primary copy is unchanged.
- R8: `flag_we` writes `flag_data` into bits [7:0] of pair 0, leaving bits [15:8]; with an armed flag redirect it writes the shadow pair 0 instead.
- R9: The prefix is one-shot: it is disarmed by the first cycle with any operation strobe (`wr_en`, `flag_we`, `ex_all`, `ex_af`, `ex_dehl`, `ld_alt_en`) after it is armed, even when both redirect controls were low.
- R10: `ld_alt_en` copies primary pair 1 (`ld_alt_src`=0) or pair 2 (`ld_alt_src`=1) into the shadow copy of pair `ld_alt_dst`, independent of any prefix; primary values are unchanged.
- R11: All strobes of one cycle act on the bank mapping and prefix state from before the edge; a `pfx_set` in the same cycle arms the prefix for the following operation. On one slot the order of precedence is flag write over register write over shadow copy over pair swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_sel | input | RD_PORTS x 2 | Pair code per read port |
| rd_data | output | RD_PORTS x DATA_W | Primary pair value per read port |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Pair code of the write |
| wr_data | input | DATA_W | Write data |
| flag_we | input | 1 | Flag write strobe |
| flag_data | input | DATA_W/2 | Flag byte |
| pfx_set | input | 1 | Prefix arm strobe |
| pfx_alt_reg | input | 1 | Prefix redirects the register result |
| pfx_alt_flag | input | 1 | Prefix redirects the flag result |
| ex_all | input | 1 | Exchange pairs 1 to 3 with shadows |
| ex_af | input | 1 | Exchange pair 0 with shadow |
| ex_dehl | input | 1 | Swap pair 2 with pair 3 (or shadow 3) |
| ld_alt_en | input | 1 | Copy primary pair into a shadow pair |
| ld_alt_src | input | 1 | Copy source: 0 pair 1, 1 pair 2 |
| ld_alt_dst | input | 2 | Copy destination pair code |

## Verification
The bench builds the block with its defaults, 16-bit pairs and two read ports, so each check reads all four primary pairs through both ports with the ports crossed. Shadow contents become visible only by exchanging banks, so directed steps follow each redirect with an exchange, and the random phase mixes overlapping strobes in one cycle, which reaches the same-cycle precedence and prefix arming rules.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  localparam int PAIR_W    = 2;
  localparam int NUM_PAIRS = 4;
  localparam int IDX_AF    = 0;
  localparam int IDX_BC    = 1;
  localparam int IDX_DE    = 2;
  localparam int IDX_HL    = 3;
endpackage

// File: rtl/regbank_bank_map.sv
module regbank_bank_map
  import regbank_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ex_all,
  input  logic                 ex_af,
  output logic [NUM_PAIRS-1:0] bank_sel
);
  logic [NUM_PAIRS-1:0] sel_nxt;
  logic                 sel_en;

  always_comb begin
    sel_en  = ex_all | ex_af;
    sel_nxt = bank_sel ^ {{(NUM_PAIRS-1){ex_all}}, ex_af};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bank_sel <= '0;
    else if (sel_en) bank_sel <= sel_nxt;
  end
endmodule

// File: rtl/regbank_prefix_ctl.sv
module regbank_prefix_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic pfx_set,
  input  logic pfx_alt_reg,
  input  logic pfx_alt_flag,
  input  logic op_any,
  output logic pfx_act,
  output logic redir_reg,
  output logic redir_flag
);
  logic act_q, reg_q, flag_q;
  logic act_d, reg_d, flag_d;
  logic upd_en;

  always_comb begin
    upd_en = pfx_set | (act_q & op_any);
    act_d  = pfx_set;
    reg_d  = pfx_set & pfx_alt_reg;
    flag_d = pfx_set & pfx_alt_flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      reg_q  <= 1'b0;
      flag_q <= 1'b0;
    end else if (upd_en) begin
      act_q  <= act_d;
      reg_q  <= reg_d;
      flag_q <= flag_d;
    end
  end

  assign pfx_act    = act_q;
  assign redir_reg  = act_q & reg_q;
  assign redir_flag = act_q & flag_q;
endmodule

// File: rtl/regbank_pair_store.sv
module regbank_pair_store
  import regbank_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int RD_PORTS = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_PAIRS-1:0]               bank_sel,
  input  logic                               wr_en,
  input  logic [PAIR_W-1:0]                  wr_sel,
  input  logic [DATA_W-1:0]                  wr_data,
  input  logic                               wr_alt,
  input  logic                               flag_we,
  input  logic [DATA_W/2-1:0]                flag_data,
  input  logic                               flag_alt,
  input  logic                               xdh_en,
  input  logic                               xdh_alt,
  input  logic                               ld_en,
  input  logic                               ld_src,
  input  logic [PAIR_W-1:0]                  ld_dst,
  input  logic [RD_PORTS-1:0][PAIR_W-1:0]    rd_sel,
  output logic [RD_PORTS-1:0][DATA_W-1:0]    rd_data
);
  localparam int FLAG_W = DATA_W / 2;

  logic [NUM_PAIRS-1:0][1:0][DATA_W-1:0] slot_val;
  logic [NUM_PAIRS-1:0][DATA_W-1:0]      prim;
  logic [DATA_W-1:0]                     hl_shadow;
  logic [DATA_W-1:0]                     ld_val;

  assign hl_shadow = slot_val[IDX_HL][~bank_sel[IDX_HL]];
  assign ld_val    = ld_src ? prim[IDX_DE] : prim[IDX_BC];

  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
    localparam bit IS_AF = (p == IDX_AF);
    localparam bit IS_DE = (p == IDX_DE);
    localparam bit IS_HL = (p == IDX_HL);

    assign prim[p] = slot_val[p][bank_sel[p]];

    for (genvar b = 0; b < 2; b++) begin : g_bank
      logic [DATA_W-1:0] q;
      logic [DATA_W-1:0] d;
      logic              en;
      logic              hit_x, hit_ld, hit_wr, hit_fl;

      always_comb begin
        hit_x  = xdh_en & ((IS_DE & (bank_sel[p] == 1'(b))) |
                           (IS_HL & ((bank_sel[p] ^ xdh_alt) == 1'(b))));
        hit_ld = ld_en & (ld_dst == PAIR_W'(p)) & (~bank_sel[p] == 1'(b));
        hit_wr = wr_en & (wr_sel == PAIR_W'(p)) & ((bank_sel[p] ^ wr_alt) == 1'(b));
        hit_fl = flag_we & IS_AF & ((bank_sel[p] ^ flag_alt) == 1'(b));
        en     = hit_x | hit_ld | hit_wr | hit_fl;
        d      = q;
        if (hit_x)  d = IS_DE ? (xdh_alt ? hl_shadow : prim[IDX_HL]) : prim[IDX_DE];
        if (hit_ld) d = ld_val;
        if (hit_wr) d = wr_data;
        if (hit_fl) d[FLAG_W-1:0] = flag_data;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= d;
      end

      assign slot_val[p][b] = q;
    end
  end

  for (genvar r = 0; r < RD_PORTS; r++) begin : g_rd
    assign rd_data[r] = prim[rd_sel[r]];
  end
endmodule

// File: rtl/dual_bank_regfile.sv
module dual_bank_regfile
  import regbank_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int RD_PORTS = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [RD_PORTS-1:0][1:0]        rd_sel,
  output logic [RD_PORTS-1:0][DATA_W-1:0] rd_data,
  input  logic                            wr_en,
  input  logic [1:0]                      wr_sel,
  input  logic [DATA_W-1:0]               wr_data,
  input  logic                            flag_we,
  input  logic [DATA_W/2-1:0]             flag_data,
  input  logic                            pfx_set,
  input  logic                            pfx_alt_reg,
  input  logic                            pfx_alt_flag,
  input  logic                            ex_all,
  input  logic                            ex_af,
  input  logic                            ex_dehl,
  input  logic                            ld_alt_en,
  input  logic                            ld_alt_src,
  input  logic [1:0]                      ld_alt_dst
);
  logic [1:0]           rst_pipe;
  logic                 rst_int_n;
  logic [NUM_PAIRS-1:0] bank_sel;
  logic                 op_any;
  logic                 pfx_act, redir_reg, redir_flag;

  // reset asserts at once and releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  assign op_any = wr_en | flag_we | ex_all | ex_af | ex_dehl | ld_alt_en;

  regbank_bank_map u_map (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .ex_all   (ex_all),
    .ex_af    (ex_af),
    .bank_sel (bank_sel)
  );

  regbank_prefix_ctl u_pfx (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .pfx_set      (pfx_set),
    .pfx_alt_reg  (pfx_alt_reg),
    .pfx_alt_flag (pfx_alt_flag),
    .op_any       (op_any),
    .pfx_act      (pfx_act),
    .redir_reg    (redir_reg),
    .redir_flag   (redir_flag)
  );

  regbank_pair_store #(.DATA_W(DATA_W), .RD_PORTS(RD_PORTS)) u_store (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .bank_sel  (bank_sel),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .wr_alt    (redir_reg),
    .flag_we   (flag_we),
    .flag_data (flag_data),
    .flag_alt  (redir_flag),
    .xdh_en    (ex_dehl),
    .xdh_alt   (redir_reg),
    .ld_en     (ld_alt_en),
    .ld_src    (ld_alt_src),
    .ld_dst    (ld_alt_dst),
    .rd_sel    (rd_sel),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/dual_bank_regfile_chk.sv
module dual_bank_regfile_chk #(
  parameter int DATA_W   = 16,
  parameter int RD_PORTS = 2
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic [3:0]                      bank_sel,
  input logic                            pfx_act,
  input logic                            pfx_set,
  input logic                            op_any,
  input logic                            ex_all,
  input logic                            ex_af,
  input logic [RD_PORTS-1:0][1:0]        rd_sel,
  input logic [RD_PORTS-1:0][DATA_W-1:0] rd_data
);
  a_r3_ex_all_flips: assert property (@(posedge clk) disable iff (!rst_n)
    ex_all |=> bank_sel[3:1] == ~$past(bank_sel[3:1]));

  a_r3_af_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_all && !ex_af) |=> $stable(bank_sel[0]));

  a_r4_ex_af_flips: assert property (@(posedge clk) disable iff (!rst_n)
    ex_af |=> bank_sel[0] != $past(bank_sel[0]));

  a_r4_others_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_af && !ex_all) |=> $stable(bank_sel[3:1]));

  a_r9_prefix_consumed: assert property (@(posedge clk) disable iff (!rst_n)
    (pfx_act && op_any && !pfx_set) |=> !pfx_act);

  a_r11_prefix_arms: assert property (@(posedge clk) disable iff (!rst_n)
    pfx_set |=> pfx_act);

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !op_any |=> (!$stable(rd_sel) || $stable(rd_data)));
endmodule

bind dual_bank_regfile dual_bank_regfile_chk #(.DATA_W(DATA_W), .RD_PORTS(RD_PORTS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_int_n),
  .bank_sel (bank_sel),
  .pfx_act  (pfx_act),
  .pfx_set  (pfx_set),
  .op_any   (op_any),
  .ex_all   (ex_all),
  .ex_af    (ex_af),
  .rd_sel   (rd_sel),
  .rd_data  (rd_data)
);

// File: tb/tb_dual_bank_regfile.sv
`timescale 1ns/1ps
module tb_dual_bank_regfile;
  logic             clk = 1'b0;
  logic             rst_n;
  logic [1:0][1:0]  rd_sel;
  logic [1:0][15:0] rd_data;
  logic             wr_en, flag_we, pfx_set, pfx_alt_reg, pfx_alt_flag;
  logic             ex_all, ex_af, ex_dehl, ld_alt_en, ld_alt_src;
  logic [1:0]       wr_sel, ld_alt_dst;
  logic [15:0]      wr_data;
  logic [7:0]       flag_data;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 0;

  logic [15:0] mp [4];
  logic [15:0] ma [4];
  bit m_act, m_reg, m_flag;

  always #2.5 clk = ~clk;

  dual_bank_regfile dut (.*);

  task automatic idle_inputs();
    wr_en = 0; flag_we = 0; pfx_set = 0; pfx_alt_reg = 0; pfx_alt_flag = 0;
    ex_all = 0; ex_af = 0; ex_dehl = 0; ld_alt_en = 0; ld_alt_src = 0;
    wr_sel = 0; ld_alt_dst = 0; wr_data = 0; flag_data = 0;
  endtask

  task automatic model_step();
    logic [15:0] np [4];
    logic [15:0] na [4];
    logic [15:0] t;
    bit rr, rf, any;
    np = mp; na = ma;
    rr = m_act & m_reg;
    rf = m_act & m_flag;
    if (ex_dehl) begin
      if (rr) begin np[2] = ma[3]; na[3] = mp[2]; end
      else    begin np[2] = mp[3]; np[3] = mp[2]; end
    end
    if (ld_alt_en) na[ld_alt_dst] = ld_alt_src ? mp[2] : mp[1];
    if (wr_en) begin
      if (rr) na[wr_sel] = wr_data; else np[wr_sel] = wr_data;
    end
    if (flag_we) begin
      if (rf) na[0][7:0] = flag_data; else np[0][7:0] = flag_data;
    end
    if (ex_all) for (int i = 1; i < 4; i++) begin t = np[i]; np[i] = na[i]; na[i] = t; end
    if (ex_af) begin t = np[0]; np[0] = na[0]; na[0] = t; end
    any = wr_en | flag_we | ex_all | ex_af | ex_dehl | ld_alt_en;
    if (pfx_set) begin m_act = 1; m_reg = pfx_alt_reg; m_flag = pfx_alt_flag; end
    else if (any) begin m_act = 0; m_reg = 0; m_flag = 0; end
    mp = np; ma = na;
  endtask

  task automatic check_reads(input string tag);
    for (int s = 0; s < 2; s++) begin
      rd_sel[0] = 2'(s);     rd_sel[1] = 2'(s + 2);
      #0.2;
      for (int r = 0; r < 2; r++) begin
        n_checks++;
        if (rd_data[r] !== mp[rd_sel[r]]) begin
          n_fails++;
          $display("FAIL %s port %0d pair %0d actual=%h expected=%h",
                   tag, r, rd_sel[r], rd_data[r], mp[rd_sel[r]]);
        end
      end
      rd_sel[0] = 2'(s + 2); rd_sel[1] = 2'(s);
      #0.2;
      for (int r = 0; r < 2; r++) begin
        n_checks++;
        if (rd_data[r] !== mp[rd_sel[r]]) begin
          n_fails++;
          $display("FAIL %s port %0d pair %0d actual=%h expected=%h",
                   tag, r, rd_sel[r], rd_data[r], mp[rd_sel[r]]);
        end
      end
    end
  endtask

  // inputs are set at a falling edge; one rising edge applies them
  task automatic step(input string tag);
    @(posedge clk);
    model_step();
    @(negedge clk);
    idle_inputs();
    check_reads(tag);
  endtask

  task automatic wr(input logic [1:0] p, input logic [15:0] v, input string tag);
    wr_en = 1; wr_sel = p; wr_data = v; step(tag);
  endtask

  task automatic arm(input bit r, input bit f, input string tag);
    pfx_set = 1; pfx_alt_reg = r; pfx_alt_flag = f; step(tag);
  endtask

  initial begin
    int unsigned seed;
    seed = $urandom(32'h1d2c3b4a);
    rd_sel = '0;
    idle_inputs();
    for (int i = 0; i < 4; i++) begin mp[i] = 0; ma[i] = 0; end
    m_act = 0; m_reg = 0; m_flag = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    // R1: reset values, both banks
    check_reads("R1");
    ex_all = 1; ex_af = 1; step("R1");
    ex_all = 1; ex_af = 1; step("R1");

    // R2: plain writes
    wr(0, 16'h1234, "R2"); wr(1, 16'hb0c1, "R2");
    wr(2, 16'hd0e1, "R2"); wr(3, 16'h4a11, "R2");

    // R3 / R4: exchanges
    ex_all = 1; step("R3");
    wr(1, 16'h0bc1, "R3"); wr(3, 16'h0bb3, "R3");
    ex_all = 1; step("R3");
    ex_af = 1; step("R4");
    wr(0, 16'h0af0, "R4");
    ex_af = 1; step("R4");

    // R5: primary DE/HL swap
    ex_dehl = 1; step("R5");

    // R6: prefixed swap uses shadow HL
    arm(1, 0, "R6");
    ex_dehl = 1; step("R6");
    ex_all = 1; step("R6");
    ex_all = 1; step("R6");

    // R7: register redirect
    arm(1, 0, "R7");
    wr(1, 16'hcafe, "R7");
    ex_all = 1; step("R7");
    ex_all = 1; step("R7");

    // R8: flag writes, plain then redirected
    flag_we = 1; flag_data = 8'h5a; step("R8");
    arm(0, 1, "R8");
    flag_we = 1; flag_data = 8'hc3; step("R8");
    ex_af = 1; step("R8");
    ex_af = 1; step("R8");

    // R9: one-shot; empty prefix is still consumed
    arm(1, 1, "R9");
    wr(2, 16'h7777, "R9");
    wr(2, 16'h8888, "R9");
    arm(0, 0, "R9");
    wr(3, 16'h9999, "R9");
    ex_all = 1; step("R9");
    ex_all = 1; step("R9");

    // R10: shadow copies, prefix ignored
    ld_alt_en = 1; ld_alt_src = 0; ld_alt_dst = 3; step("R10");
    arm(1, 1, "R10");
    ld_alt_en = 1; ld_alt_src = 1; ld_alt_dst = 1; step("R10");
    ld_alt_en = 1; ld_alt_src = 1; ld_alt_dst = 0; step("R10");
    ex_all = 1; ex_af = 1; step("R10");
    ex_all = 1; ex_af = 1; step("R10");

    // R11: same-cycle combinations
    wr_en = 1; wr_sel = 2; wr_data = 16'habcd; ex_all = 1; step("R11");
    pfx_set = 1; pfx_alt_reg = 1; wr_en = 1; wr_sel = 1; wr_data = 16'h1111; step("R11");
    wr(1, 16'h2222, "R11");
    wr_en = 1; wr_sel = 0; wr_data = 16'hfe00; flag_we = 1; flag_data = 8'h77; step("R11");
    ex_all = 1; ex_af = 1; step("R11");

    // random mix
    for (int k = 0; k < 3000; k++) begin
      wr_en        = ($urandom % 10) < 4;
      wr_sel       = 2'($urandom);
      wr_data      = 16'($urandom);
      flag_we      = ($urandom % 10) < 2;
      flag_data    = 8'($urandom);
      ex_all       = ($urandom % 10) == 0;
      ex_af        = ($urandom % 10) == 0;
      ex_dehl      = ($urandom % 10) == 0;
      ld_alt_en    = ($urandom % 10) == 0;
      ld_alt_src   = 1'($urandom);
      ld_alt_dst   = 2'($urandom);
      pfx_set      = ($urandom % 10) < 2;
      pfx_alt_reg  = 1'($urandom);
      pfx_alt_flag = 1'($urandom);
      step("R2/R11");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog R1 actual=timeout expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule